// File: doc/BRIEF.md
# Trinomial-field product reducer

This block takes the double-width result of a carry-less multiply or square and brings it back into a binary extension field. The field is defined by the trinomial x^DEG + x^MID + 1, with DEG = 233 and MID = 74 by default. The product arrives as four words of WORD_W bits, least significant word first. The reduced field element leaves as two words of WORD_W bits. Only bits 0 through DEG-1 of the output can be set.

The reduction uses fixed shift-and-XOR folding and no multiplier. Each fold takes the part of the vector at or above bit DEG, shifts it down by DEG, and XORs it back into the low part twice: once unshifted, and once shifted up by MID. The upper part is realigned by DEG bits, which is 256 − 233 = 23 bits relative to the output word. The middle term lands MID − 64 = 10 bits into its 64-bit lane. Enough folds are generated from the parameters to clear every input bit. A final mask then keeps exactly DEG bits.

One register stage sits behind the folding logic. A strobe on the input side is answered by a strobe on the output side one clock later.

Top module: `tri_fold_reducer`

## Requirements
- R1: For any input product of up to 4·WORD_W bits, the output equals the product modulo x^DEG + x^MID + 1. Bit i of the concatenation {prod_w3, prod_w2, prod_w1, prod_w0} is the coefficient of x^i. Bit i of {res_w1, res_w0} is the coefficient of x^i.
- R2: Every output bit at position DEG or above is zero. With the default parameters, res_w1 keeps its low three 32-bit words plus the low 9 bits of its top 32-bit word, which is 105 bits in all.
- R3: When in_valid is high at a rising clock edge, out_valid is high after that edge, and the result for that input is on res_w0/res_w1.
- R4: out_valid is low while reset is asserted and directly after it. out_valid is also low after any edge at which in_valid was low.
- R5: An edge at which in_valid is low leaves the output words unchanged.
- R6: An input whose degree is below DEG comes out unchanged.
- R7: An input equal to the field polynomial itself reduces to zero.
- R8: The single term x^DEG reduces to x^MID + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input product is valid this cycle |
| prod_w0 | input | WORD_W | Product bits WORD_W-1..0 |
| prod_w1 | input | WORD_W | Product bits 2·WORD_W-1..WORD_W |
| prod_w2 | input | WORD_W | Product bits 3·WORD_W-1..2·WORD_W |
| prod_w3 | input | WORD_W | Product bits 4·WORD_W-1..3·WORD_W |
| out_valid | output | 1 | Result words are valid |
| res_w0 | output | WORD_W | Reduced element, bits WORD_W-1..0 |
| res_w1 | output | WORD_W | Reduced element, bits 2·WORD_W-1..WORD_W |

## Verification
The bench builds two instances.

The first is a toy field with WORD_W = 4, DEG = 7 and MID = 3. Its 16-bit input space is small enough to sweep in full. That sweep covers every pass-through value, the polynomial itself, x^7, and every pattern of folded carries against a long-division model.

The second is the default 233-bit field with WORD_W = 128. It takes the single-term and polynomial corners, an all-ones 512-bit product, a short input, and a few hundred random products. These reach the second fold and the 105-bit upper-word mask, which the toy field exercises only in miniature.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  // Number of folds needed until the top possible bit drops below deg.
  function automatic int fold_count(int top_bit, int deg, int mid);
    int d;
    int n;
    d = top_bit;
    n = 0;
    while (d >= deg) begin
      d = d - deg + mid;
      n = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/tfr_fold_stage.sv
module tfr_fold_stage #(
  parameter int W   = 512,
  parameter int DEG = 233,
  parameter int MID = 74
) (
  input  logic [W-1:0] v_in,
  output logic [W-1:0] v_out
);
  localparam logic [W-1:0] LOW_MASK = {{(W-DEG){1'b0}}, {DEG{1'b1}}};

  logic [W-1:0] hi_part;

  always_comb begin
    hi_part = v_in >> DEG;
    // x^(DEG+k) == x^(MID+k) + x^k
    v_out   = (v_in & LOW_MASK) ^ hi_part ^ (hi_part << MID);
  end
endmodule

// File: rtl/tfr_trim.sv
module tfr_trim #(
  parameter int W     = 512,
  parameter int OUT_W = 256,
  parameter int DEG   = 233
) (
  input  logic [W-1:0]     v_in,
  output logic [OUT_W-1:0] v_out
);
  localparam logic [OUT_W-1:0] KEEP_MASK = {{(OUT_W-DEG){1'b0}}, {DEG{1'b1}}};

  logic unused_hi;

  always_comb begin
    unused_hi = ^v_in[W-1:OUT_W];
    v_out     = v_in[OUT_W-1:0] & KEEP_MASK;
  end
endmodule

// File: rtl/tri_fold_reducer.sv
module tri_fold_reducer #(
  parameter int WORD_W = 128,
  parameter int DEG    = 233,
  parameter int MID    = 74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] prod_w0,
  input  logic [WORD_W-1:0] prod_w1,
  input  logic [WORD_W-1:0] prod_w2,
  input  logic [WORD_W-1:0] prod_w3,
  output logic              out_valid,
  output logic [WORD_W-1:0] res_w0,
  output logic [WORD_W-1:0] res_w1
);
  localparam int IN_W      = 4 * WORD_W;
  localparam int OUT_W     = 2 * WORD_W;
  localparam int NUM_FOLDS = tfr_pkg::fold_count(IN_W - 1, DEG, MID);

  logic [IN_W-1:0]  prod_all;
  logic [IN_W-1:0]  stage_v [0:NUM_FOLDS];
  logic [OUT_W-1:0] reduced;
  logic [OUT_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;
  logic [OUT_W-1:0] res_all;

  assign prod_all   = {prod_w3, prod_w2, prod_w1, prod_w0};
  assign stage_v[0] = prod_all;

  for (genvar g = 0; g < NUM_FOLDS; g++) begin : g_fold
    tfr_fold_stage #(.W(IN_W), .DEG(DEG), .MID(MID)) u_fold (
      .v_in  (stage_v[g]),
      .v_out (stage_v[g+1])
    );
  end

  tfr_trim #(.W(IN_W), .OUT_W(OUT_W), .DEG(DEG)) u_trim (
    .v_in  (stage_v[NUM_FOLDS]),
    .v_out (reduced)
  );

  // next-state
  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? reduced : res_q;
  end

  // data register: enabled, not reset
  always_ff @(posedge clk) begin
    if (in_valid) res_q <= res_d;
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q;
  assign res_all   = res_q;
  assign res_w0    = res_q[WORD_W-1:0];
  assign res_w1    = res_q[OUT_W-1:WORD_W];
endmodule

// File: rtl/tfr_check.sv
module tfr_check #(
  parameter int IN_W  = 512,
  parameter int OUT_W = 256,
  parameter int DEG   = 233
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [IN_W-1:0]  prod_all,
  input logic             out_valid,
  input logic [OUT_W-1:0] res_all
);
  // R3
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R4
  idle_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  mask_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((res_all >> DEG) == '0));

  // R5
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> $stable(res_all));

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((prod_all >> DEG) == '0)) |=> (res_all == $past(prod_all[OUT_W-1:0])));
endmodule

bind tri_fold_reducer tfr_check #(.IN_W(4*WORD_W), .OUT_W(2*WORD_W), .DEG(DEG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .prod_all  (prod_all),
  .out_valid (out_valid),
  .res_all   (res_all)
);

// File: tb/tb_tri_fold_reducer.sv
module tb_tri_fold_reducer;
  localparam int CLK_PERIOD = 10;
  localparam int S_W = 4, S_DEG = 7, S_MID = 3;
  localparam int B_W = 128, B_DEG = 233, B_MID = 74;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  // toy field instance
  logic           s_vld;
  logic [4*S_W-1:0] s_in;
  logic           s_ovld;
  logic [S_W-1:0] s_r0, s_r1;

  tri_fold_reducer #(.WORD_W(S_W), .DEG(S_DEG), .MID(S_MID)) dut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_vld),
    .prod_w0(s_in[S_W-1:0]), .prod_w1(s_in[2*S_W-1:S_W]),
    .prod_w2(s_in[3*S_W-1:2*S_W]), .prod_w3(s_in[4*S_W-1:3*S_W]),
    .out_valid(s_ovld), .res_w0(s_r0), .res_w1(s_r1));

  // default field instance
  logic             b_vld;
  logic [511:0]     b_in;
  logic             b_ovld;
  logic [B_W-1:0]   b_r0, b_r1;

  tri_fold_reducer #(.WORD_W(B_W), .DEG(B_DEG), .MID(B_MID)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(b_vld),
    .prod_w0(b_in[127:0]), .prod_w1(b_in[255:128]),
    .prod_w2(b_in[383:256]), .prod_w3(b_in[511:384]),
    .out_valid(b_ovld), .res_w0(b_r0), .res_w1(b_r1));

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  function automatic logic [511:0] ref_mod(logic [511:0] v, int deg, int mid);
    for (int i = 511; i >= deg; i--) begin
      if (v[i]) begin
        v[i]           = 1'b0;
        v[i-deg]       = ~v[i-deg];
        v[i-deg+mid]   = ~v[i-deg+mid];
      end
    end
    return v;
  endfunction

  task automatic check(string tag, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  function automatic string small_tag(int v);
    if (v == 16'h0089) return "R7";
    if (v == 16'h0080) return "R8";
    if (v < 128)       return "R6";
    return "R1";
  endfunction

  initial begin
    logic [511:0] exp_s, exp_b, vec, prev_res;
    string        tag_s, tag_b;
    rst_n = 1'b0; s_vld = 1'b0; b_vld = 1'b0; s_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    check("R4 reset small out_valid", {511'b0, s_ovld}, 512'd0);
    check("R4 reset big out_valid",   {511'b0, b_ovld}, 512'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 after reset out_valid", {511'b0, s_ovld | b_ovld}, 512'd0);

    // exhaustive toy sweep, one vector per cycle
    exp_s = '0; tag_s = "";
    for (int v = 0; v < 65536; v++) begin
      if (v > 0) begin
        check({tag_s, " R3 valid"}, {511'b0, s_ovld}, 512'd1);
        check({tag_s, " R2 value"}, {496'b0, s_r1, s_r0}, exp_s);
      end
      s_in  = v[15:0];
      s_vld = 1'b1;
      tag_s = small_tag(v);
      if (v < 128)            exp_s = 512'(v);
      else if (v == 16'h0089) exp_s = '0;
      else if (v == 16'h0080) exp_s = 512'h09;
      else                    exp_s = ref_mod(512'(v), S_DEG, S_MID);
      @(negedge clk);
    end
    check({tag_s, " R3 last"}, {496'b0, s_r1, s_r0}, exp_s);
    prev_res = {496'b0, s_r1, s_r0};
    s_vld = 1'b0;
    s_in  = 16'h1234;
    @(negedge clk);
    check("R4 small idle out_valid", {511'b0, s_ovld}, 512'd0);
    @(negedge clk);
    check("R5 small hold", {496'b0, s_r1, s_r0}, prev_res);

    // default field: corners then random
    exp_b = '0; tag_b = "";
    for (int n = 0; n < 400; n++) begin
      if (n > 0) begin
        check({tag_b, " R3 valid"}, {511'b0, b_ovld}, 512'd1);
        check({tag_b}, {256'b0, b_r1, b_r0}, exp_b);
        check("R2 upper word mask", {256'b0, b_r1 >> 105, 128'b0}, 512'd0);
      end
      vec = '0;
      for (int k = 0; k < 16; k++) vec[k*32 +: 32] = $urandom;
      case (n)
        0: begin vec = '0; vec[233] = 1'b1; tag_b = "R8"; exp_b = '0; exp_b[74] = 1'b1; exp_b[0] = 1'b1; end
        1: begin vec = '0; vec[233] = 1'b1; vec[74] = 1'b1; vec[0] = 1'b1; tag_b = "R7"; exp_b = '0; end
        2: begin vec = vec & ((512'd1 << 233) - 1); tag_b = "R6"; exp_b = vec; end
        3: begin vec = '1; tag_b = "R1 all ones"; exp_b = ref_mod(vec, B_DEG, B_MID); end
        4: begin vec = vec & ((512'd1 << 465) - 1); tag_b = "R1 deg464"; exp_b = ref_mod(vec, B_DEG, B_MID); end
        default: begin tag_b = "R1 random"; exp_b = ref_mod(vec, B_DEG, B_MID); end
      endcase
      b_in  = vec;
      b_vld = 1'b1;
      @(negedge clk);
    end
    check({tag_b, " last"}, {256'b0, b_r1, b_r0}, exp_b);
    prev_res = {256'b0, b_r1, b_r0};
    b_vld = 1'b0;
    b_in  = '1;
    @(negedge clk);
    check("R4 big idle out_valid", {511'b0, b_ovld}, 512'd0);
    @(negedge clk);
    check("R5 big hold", {256'b0, b_r1, b_r0}, prev_res);

    finish_run();
  end
endmodule